// File: doc/BRIEF.md
# Slow-Clock Watchdog with Early Warning

This block is a supervision timer that counts edges of a slow, free-running clock of roughly 1 kHz. That clock is independent of the processor bus clock. Software picks one of twelve power-of-two timeout lengths and an early-warning distance, then starts the timer. From then on it must send clear commands often enough. If the count reaches the chosen length with no clear, the block raises a reset request for a fixed number of slow cycles. It then restarts the count and keeps supervising.

Commands arrive in the bus clock domain. Each accepted command is carried into the slow domain by a toggle handshake. A busy flag stays high until the slow domain has applied the command, and commands offered while busy are dropped. Once started, the timer is locked. It cannot be stopped or reconfigured until the slow-domain reset is applied. It goes on counting if the bus clock stops.

Top module: `lsc_watchdog`

## Requirements
- R1: While not started, the block holds `rst_req` and `warn_irq` low for any number of slow clock edges. Once started, the internal count advances by one on each slow edge that applies no command and hits no timeout.
- R2: A `cfg_period` value s selects a timeout of P = 8·2^s slow cycles, and values 12 to 15 behave as 11. With no clears, consecutive rising edges of `rst_req` are exactly P slow edges apart. The first rising edge comes P slow edges after the start command is applied.
- R3: Each timeout drives `rst_req` high for exactly 2 slow clock cycles.
- R4: A `cfg_warn` value w makes `warn_irq` rise exactly 2^w slow edges before each `rst_req` rising edge, provided 2^w < P. Otherwise `warn_irq` never rises. `warn_irq` is low from the edge where `rst_req` rises, and it drops once a clear is applied.
- R5: `busy` is high from the bus cycle after a command is accepted until the slow domain has applied that command. A `cfg_wr` or `clr_wr` pulse that arrives while `busy` is high is ignored. If both pulses arrive together, the configuration is taken.
- R6: An applied clear restarts the count from zero. Clears spaced closer than P slow cycles keep `rst_req` low indefinitely.
- R7: After a configuration with `cfg_en`=1 has been applied, further configuration writes are ignored until `wd_rst_n` is asserted. This covers writes with `cfg_en`=0 and writes with a new period.
- R8: The slow-domain timer keeps counting and issuing reset pulses while `bus_clk` is stopped.
- R9: After reset, `busy`, `rst_req` and `warn_irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for the command side |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| cfg_wr | input | 1 | One-cycle pulse: write configuration |
| cfg_en | input | 1 | Start the timer (used with `cfg_wr`) |
| cfg_period | input | 4 | Timeout select s, P = 8·2^s slow cycles |
| cfg_warn | input | 4 | Warning distance select w, 2^w cycles before timeout |
| clr_wr | input | 1 | One-cycle pulse: clear (service) the timer |
| busy | output | 1 | A command is in flight to the slow domain |
| wd_clk | input | 1 | Slow, independent watchdog clock |
| wd_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| rst_req | output | 1 | Reset request pulse, slow domain |
| warn_irq | output | 1 | Early-warning interrupt level, slow domain |

## Verification
The properties assume several things about the inputs. Both resets are asserted together at start-up and are released away from their clock edges. `cfg_wr` and `clr_wr` are single bus-cycle pulses, and the command fields are only meaningful in the cycle a pulse is present. The stimulus drives every input on the falling bus edge, and it holds each command for exactly one cycle. It only issues a new command after waiting for `busy` to drop, except in the one test that deliberately offers a command while busy. The stimulus never changes the configuration fields of a running timer expecting an effect, and it only stops `bus_clk` while no command is in flight.

// File: rtl/lsc_wdog_pkg.sv
package lsc_wdog_pkg;

  // log2 of the shortest timeout in slow cycles
  localparam int BASE_LOG2 = 3;
  // number of distinct timeout selections
  localparam int NUM_SEL   = 12;
  localparam int SEL_W     = 4;
  localparam int WARN_W    = 4;
  // wide enough for the longest timeout minus one
  localparam int CNT_W     = BASE_LOG2 + NUM_SEL;

  typedef enum logic {
    CMD_CFG = 1'b0,
    CMD_CLR = 1'b1
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e           kind;
    logic                en;
    logic [SEL_W-1:0]    sel;
    logic [WARN_W-1:0]   warn;
  } cmd_t;

  // selections above the last legal one fall back to the longest timeout
  function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] s);
    return (int'(s) > NUM_SEL - 1) ? SEL_W'(NUM_SEL - 1) : s;
  endfunction

  // timeout length in slow cycles for a (clamped) selection
  function automatic logic [CNT_W-1:0] period_cycles(input logic [SEL_W-1:0] s);
    return CNT_W'(1) << (BASE_LOG2 + int'(clamp_sel(s)));
  endfunction

  // a warning exists only when its distance is strictly inside the period
  function automatic logic warn_valid(input logic [SEL_W-1:0] s,
                                      input logic [WARN_W-1:0] w);
    return (32'd1 << w) < 32'(period_cycles(s));
  endfunction

  // count value at which the warning is registered
  function automatic logic [CNT_W-1:0] warn_point(input logic [SEL_W-1:0] s,
                                                  input logic [WARN_W-1:0] w);
    return period_cycles(s) - CNT_W'((32'd1 << w) + 32'd1);
  endfunction

endpackage

// File: rtl/lsc_wdog_sync.sv
module lsc_wdog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lsc_wdog_bus_port.sv
module lsc_wdog_bus_port
  import lsc_wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [SEL_W-1:0]  cfg_period,
  input  logic [WARN_W-1:0] cfg_warn,
  input  logic              clr_wr,
  input  logic              ack_tgl,
  output logic              req_tgl,
  output cmd_t              cmd_q,
  output logic              busy,
  output logic              cmd_accept
);

  logic ack_s;

  lsc_wdog_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d     (ack_tgl),
    .q     (ack_s)
  );

  // a command is outstanding while the returned toggle lags the request
  assign busy       = req_tgl ^ ack_s;
  assign cmd_accept = (cfg_wr | clr_wr) & ~busy;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_tgl <= 1'b0;
      cmd_q   <= '{kind: CMD_CFG, en: 1'b0, sel: '0, warn: '0};
    end else if (cmd_accept) begin
      req_tgl <= ~req_tgl;
      if (cfg_wr) cmd_q <= '{kind: CMD_CFG, en: cfg_en, sel: cfg_period, warn: cfg_warn};
      else        cmd_q <= '{kind: CMD_CLR, en: 1'b0, sel: '0, warn: '0};
    end
  end

endmodule

// File: rtl/lsc_wdog_cmd_rx.sv
module lsc_wdog_cmd_rx
  import lsc_wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              wd_clk,
  input  logic              wd_rst_n,
  input  logic              req_tgl,
  input  cmd_t              cmd_q,
  output logic              ack_tgl,
  output logic              apply_stb,
  output logic              restart,
  output logic              en_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [WARN_W-1:0] warn_q
);

  logic req_s;
  logic req_d;
  logic load_stb;
  logic clear_stb;

  lsc_wdog_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (wd_clk),
    .rst_n (wd_rst_n),
    .d     (req_tgl),
    .q     (req_s)
  );

  // the command fields were stable for the whole synchronizer delay
  assign apply_stb = req_s ^ req_d;
  assign load_stb  = apply_stb & (cmd_q.kind == CMD_CFG) & ~en_q;
  assign clear_stb = apply_stb & (cmd_q.kind == CMD_CLR) & en_q;
  assign restart   = load_stb | clear_stb;
  assign ack_tgl   = req_d;

  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n) req_d <= 1'b0;
    else           req_d <= req_s;
  end

  // configuration is only taken while stopped; start is one-way
  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      warn_q <= '0;
    end else if (load_stb) begin
      en_q   <= cmd_q.en;
      sel_q  <= clamp_sel(cmd_q.sel);
      warn_q <= cmd_q.warn;
    end
  end

endmodule

// File: rtl/lsc_wdog_timer.sv
module lsc_wdog_timer
  import lsc_wdog_pkg::*;
#(
  parameter int RST_CYCLES = 2
) (
  input  logic              wd_clk,
  input  logic              wd_rst_n,
  input  logic              en_q,
  input  logic [SEL_W-1:0]  sel_q,
  input  logic [WARN_W-1:0] warn_q,
  input  logic              restart,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  period_q,
  output logic              timeout_hit,
  output logic              rst_req,
  output logic              warn_irq
);

  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] pulse_q;
  logic          warn_hit;

  assign period_q    = period_cycles(sel_q);
  assign timeout_hit = en_q & (cnt_q == period_q - CNT_W'(1)) & ~restart;
  assign warn_hit    = en_q & warn_valid(sel_q, warn_q) & (cnt_q == warn_point(sel_q, warn_q));

  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n) begin
      cnt_q    <= '0;
      warn_irq <= 1'b0;
    end else if (restart || timeout_hit) begin
      cnt_q    <= '0;
      warn_irq <= 1'b0;
    end else if (en_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (warn_hit) warn_irq <= 1'b1;
    end
  end

  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n)         pulse_q <= '0;
    else if (timeout_hit)  pulse_q <= PW'(RST_CYCLES);
    else if (pulse_q != 0) pulse_q <= pulse_q - PW'(1);
  end

  assign rst_req = (pulse_q != '0);

endmodule

// File: rtl/lsc_watchdog.sv
module lsc_watchdog
  import lsc_wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [SEL_W-1:0]  cfg_period,
  input  logic [WARN_W-1:0] cfg_warn,
  input  logic              clr_wr,
  output logic              busy,
  input  logic              wd_clk,
  input  logic              wd_rst_n,
  output logic              rst_req,
  output logic              warn_irq
);

  logic              req_tgl;
  logic              ack_tgl;
  cmd_t              cmd_q;
  logic              cmd_accept;
  logic              apply_stb;
  logic              restart;
  logic              en_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WARN_W-1:0] warn_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  period_q;
  logic              timeout_hit;

  lsc_wdog_bus_port #(.SYNC_STAGES(SYNC_STAGES)) u_bus_port (
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_en     (cfg_en),
    .cfg_period (cfg_period),
    .cfg_warn   (cfg_warn),
    .clr_wr     (clr_wr),
    .ack_tgl    (ack_tgl),
    .req_tgl    (req_tgl),
    .cmd_q      (cmd_q),
    .busy       (busy),
    .cmd_accept (cmd_accept)
  );

  lsc_wdog_cmd_rx #(.SYNC_STAGES(SYNC_STAGES)) u_cmd_rx (
    .wd_clk    (wd_clk),
    .wd_rst_n  (wd_rst_n),
    .req_tgl   (req_tgl),
    .cmd_q     (cmd_q),
    .ack_tgl   (ack_tgl),
    .apply_stb (apply_stb),
    .restart   (restart),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .warn_q    (warn_q)
  );

  lsc_wdog_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
    .wd_clk      (wd_clk),
    .wd_rst_n    (wd_rst_n),
    .en_q        (en_q),
    .sel_q       (sel_q),
    .warn_q      (warn_q),
    .restart     (restart),
    .cnt_q       (cnt_q),
    .period_q    (period_q),
    .timeout_hit (timeout_hit),
    .rst_req     (rst_req),
    .warn_irq    (warn_irq)
  );

endmodule

// File: rtl/lsc_watchdog_chk.sv
module lsc_watchdog_chk
  import lsc_wdog_pkg::*;
(
  input logic             bus_clk,
  input logic             bus_rst_n,
  input logic             wd_clk,
  input logic             wd_rst_n,
  input logic             cmd_accept,
  input logic             busy,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] period_q,
  input logic             apply_stb,
  input logic             timeout_hit,
  input logic             rst_req,
  input logic             warn_irq
);

  a_r1_idle_quiet: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    !en_q |-> (!rst_req && !warn_irq));

  a_r1_count_step: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (en_q && !apply_stb && !timeout_hit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r2_no_overflow: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    en_q |-> (cnt_q < period_q));

  a_r3_min_width: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    $rose(rst_req) |=> rst_req);

  a_r4_warn_low_at_reset: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    $rose(rst_req) |-> !warn_irq);

  a_r5_busy_after_accept: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    cmd_accept |=> busy);

  a_r7_start_locked: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    en_q |=> en_q);

endmodule

bind lsc_watchdog lsc_watchdog_chk u_chk (.*);

// File: tb/lsc_watchdog_bench.sv
`timescale 1ns/1ps
module lsc_watchdog_bench;

  logic       bus_clk   = 1'b0;
  logic       wd_clk    = 1'b0;
  logic       bus_rst_n = 1'b0;
  logic       wd_rst_n  = 1'b0;
  logic       bus_run   = 1'b1;
  logic       cfg_wr    = 1'b0;
  logic       cfg_en    = 1'b0;
  logic [3:0] cfg_period = '0;
  logic [3:0] cfg_warn  = '0;
  logic       clr_wr    = 1'b0;
  logic       busy;
  logic       rst_req;
  logic       warn_irq;

  int checks = 0;
  int errors = 0;
  int wd_edges = 0;
  int rst_rises = 0, rst_rise_at = 0, rst_width = 0;
  int warn_rises = 0, warn_rise_at = 0;
  logic rst_prev = 1'b0, warn_prev = 1'b0;

  // {period select, warning select}
  localparam int VEC [6][2] = '{'{0,0}, '{0,3}, '{1,2}, '{2,4}, '{3,1}, '{1,4}};

  lsc_watchdog u_lsc_watchdog (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_period(cfg_period), .cfg_warn(cfg_warn), .clr_wr(clr_wr), .busy(busy),
    .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .rst_req(rst_req), .warn_irq(warn_irq)
  );

  always begin #2.5; if (bus_run) bus_clk = ~bus_clk; end
  always #10 wd_clk = ~wd_clk;

  always @(posedge wd_clk) wd_edges <= wd_edges + 1;

  always @(negedge wd_clk) begin
    if (rst_req === 1'b1 && rst_prev === 1'b0) begin
      rst_rises++; rst_rise_at = wd_edges;
    end
    if (rst_req === 1'b0 && rst_prev === 1'b1) rst_width = wd_edges - rst_rise_at;
    if (warn_irq === 1'b1 && warn_prev === 1'b0) begin
      warn_rises++; warn_rise_at = wd_edges;
    end
    rst_prev  = rst_req;
    warn_prev = warn_irq;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(190000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic do_reset();
    @(negedge bus_clk);
    bus_rst_n = 1'b0; wd_rst_n = 1'b0;
    repeat (3) @(negedge wd_clk);
    wd_rst_n = 1'b1;
    @(negedge bus_clk);
    bus_rst_n = 1'b1;
    repeat (2) @(negedge bus_clk);
  endtask

  task automatic send_cfg(input bit en, input int sel, input int w);
    @(negedge bus_clk);
    cfg_wr = 1'b1; cfg_en = en; cfg_period = 4'(sel); cfg_warn = 4'(w);
    @(negedge bus_clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send_clr();
    @(negedge bus_clk);
    clr_wr = 1'b1;
    @(negedge bus_clk);
    clr_wr = 1'b0;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy !== 1'b0) begin
      @(negedge bus_clk);
      cycles++;
    end
  endtask

  // waits for two reset pulses; returns the spacing and warning data at the first
  task automatic measure(output int per, output int r1, output int w_at, output int w_cnt);
    int base;
    base = rst_rises;
    wait (rst_rises == base + 1);
    r1 = rst_rise_at; w_at = warn_rise_at; w_cnt = warn_rises;
    wait (rst_rises == base + 2);
    per = rst_rise_at - r1;
  endtask

  initial begin
    int per, r1, w_at, w_cnt, cyc, wbase, base, e0, p;
    do_reset();

    // R9: reset state
    check(busy === 1'b0, "R9 busy", int'(busy), 0);
    check(rst_req === 1'b0, "R9 rst_req", int'(rst_req), 0);
    check(warn_irq === 1'b0, "R9 warn_irq", int'(warn_irq), 0);
    // R1: idle while not started
    base = rst_rises; wbase = warn_rises;
    repeat (100) @(negedge wd_clk);
    check(rst_rises == base, "R1 idle rst", rst_rises - base, 0);
    check(warn_rises == wbase, "R1 idle warn", warn_rises - wbase, 0);

    // table of period / warning pairs (R2, R3, R4)
    for (int i = 0; i < 6; i++) begin
      do_reset();
      wbase = warn_rises;
      send_cfg(1'b1, VEC[i][0], VEC[i][1]);
      wait_idle(cyc);
      measure(per, r1, w_at, w_cnt);
      p = 8 << VEC[i][0];
      check(per == p, "R2 period", per, p);
      check(rst_width == 2, "R3 pulse width", rst_width, 2);
      if ((1 << VEC[i][1]) < p)
        check(w_cnt > wbase && (r1 - w_at) == (1 << VEC[i][1]), "R4 warn lead", r1 - w_at, 1 << VEC[i][1]);
      else
        check(warn_rises == wbase, "R4 no warn", warn_rises - wbase, 0);
    end

    // R5: busy timing and a command offered while busy is dropped
    do_reset();
    send_cfg(1'b1, 0, 0);
    check(busy === 1'b1, "R5 busy after accept", int'(busy), 1);
    send_cfg(1'b1, 3, 0);
    wait_idle(cyc);
    check(cyc < 40, "R5 busy bounded", cyc, 40);
    measure(per, r1, w_at, w_cnt);
    check(per == 8, "R5 busy write ignored", per, 8);

    // R7: configuration locked after start
    send_cfg(1'b0, 2, 0);
    wait_idle(cyc);
    measure(per, r1, w_at, w_cnt);
    check(per == 8, "R7 lock keeps period", per, 8);

    // R6: regular clears hold off the reset; then it returns
    do_reset();
    send_cfg(1'b1, 2, 0);
    wait_idle(cyc);
    base = rst_rises;
    for (int k = 0; k < 20; k++) begin
      repeat (10) @(negedge wd_clk);
      send_clr();
      wait_idle(cyc);
    end
    check(rst_rises == base, "R6 clears prevent reset", rst_rises - base, 0);
    measure(per, r1, w_at, w_cnt);
    check(per == 32, "R6 resumes after clears", per, 32);

    // R4: clear drops the warning
    do_reset();
    send_cfg(1'b1, 1, 3);
    wait_idle(cyc);
    wbase = warn_rises;
    wait (warn_rises == wbase + 1);
    send_clr();
    wait_idle(cyc);
    repeat (2) @(negedge wd_clk);
    check(warn_irq === 1'b0, "R4 clear drops warn", int'(warn_irq), 0);

    // R8: counting goes on with the bus clock stopped
    do_reset();
    send_cfg(1'b1, 1, 0);
    wait_idle(cyc);
    base = rst_rises;
    bus_run = 1'b0;
    repeat (100) @(negedge wd_clk);
    check(rst_rises - base >= 6, "R8 runs without bus clock", rst_rises - base, 6);
    bus_run = 1'b1;

    // R2: out-of-range select behaves as the longest timeout
    do_reset();
    wbase = warn_rises;
    send_cfg(1'b1, 15, 0);
    wait_idle(cyc);
    e0 = wd_edges;
    base = rst_rises;
    wait (rst_rises == base + 1);
    check((rst_rise_at - e0) <= 16384 && (rst_rise_at - e0) >= 16380, "R2 clamp to 11",
          rst_rise_at - e0, 16384);
    check(warn_rises == wbase + 1 && (rst_rise_at - warn_rise_at) == 1, "R4 warn at w=0",
          rst_rise_at - warn_rise_at, 1);

    summary();
  end

endmodule